// File: doc/BRIEF.md
# Change-Detecting Priority Update Serializer

This block watches a bank of N monitored register values, each W bits wide, delivered as one flattened input vector. Each value is compared every cycle with the copy held from the previous cycle. A difference sets a sticky pending flag for that register. Many registers may change in the same cycle, and none of those changes is lost.

Each cycle the block writes at most one update into the write port of an outgoing FIFO. The word carries the register index and the value that the register holds at that moment. When several flags are pending, the register with the lowest index is served first. A register that changes often can therefore delay higher-numbered ones indefinitely, and that is accepted by design. While the FIFO reports full, no word is written and every pending flag keeps its state.

The block is sized for about a hundred monitored registers. The FIFO storage and everything on the consumer side lie outside the block.

Top module: `upd_serializer`

## Requirements
- R1: When a monitored value differs from its value in the previous cycle, its pending flag is set at the next clock edge. Its update is written no earlier than the cycle after the change.
- R2: When several registers change in the same cycle, every one of them is flagged, and each is later written exactly once.
- R3: At most one word is written per cycle. `wr_en` is high exactly when at least one flag is pending and `fifo_full` is low.
- R4: Among pending registers, the one with the lowest index is written first.
- R5: A pending flag stays set until its update is written. The value written is the register's value in the writing cycle, so repeated changes while pending produce a single word. A change that occurs in the writing cycle is carried by that word and does not raise the flag again.
- R6: While `fifo_full` is high, `wr_en` is low and no pending flag is cleared.
- R7: The output word is `{index, value}`. The index occupies the top `clog2(N)` bits and the value occupies the low W bits.
- R8: During synchronous reset (active-low `rst_n`), the stored previous values load from the inputs. After reset no update is written until a monitored value changes.
- R9: A register that is pending waits for as long as lower-indexed registers keep being flagged, and it is written once they stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_vals | input | N*W | Monitored values; register i occupies bits [i*W +: W] |
| fifo_full | input | 1 | Outgoing FIFO cannot accept a word |
| wr_en | output | 1 | Write strobe into the FIFO |
| wr_data | output | clog2(N)+W | Update word {index, value} |

## Verification
The assertions assume that `fifo_full` and `mon_vals` are stable around the rising clock edge. They also assume that reset is held for at least one clock, so that the stored copies are loaded before any comparison counts. The bench drives every input on the falling edge. It holds reset for several cycles while it loads random values, and it produces full periods, single changes, bursts of changes in one cycle and back-to-back changes to the same register only between edges.

// File: rtl/upd_serializer.sv
module upd_serializer #(
  parameter int N = 100,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int DW = IW + W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*W-1:0]  mon_vals,
  input  logic            fifo_full,
  output logic            wr_en,
  output logic [DW-1:0]   wr_data
);

  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N*W-1:0] prev_q;
  logic [N-1:0]   chg, pend_q, grant;
  logic [IW-1:0]  sel;
  logic           any_pend;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign chg[i] = mon_vals[i*W +: W] != prev_q[i*W +: W];
  end

  always_comb begin
    sel      = '0;
    any_pend = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        sel      = IW'(i);
        any_pend = 1'b1;
      end
    end
  end

  assign wr_en   = any_pend & ~fifo_full;
  assign grant   = wr_en ? (ONE << sel) : '0;
  assign wr_data = {sel, mon_vals[int'(sel)*W +: W]};

  always_ff @(posedge clk) begin
    prev_q <= mon_vals;
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | chg) & ~grant;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !wr_en);  // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> ((pend_q & $past(pend_q)) == $past(pend_q)));  // R6
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((pend_q & ((ONE << sel) - ONE)) == '0));  // R4
  AST_CLEAN_START: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend_q == '0));  // R8

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !grant[i]) |=> pend_q[i]);  // R5
    AST_CHANGE_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (chg[i] && !grant[i]) |=> pend_q[i]);  // R2
  end

endmodule

// File: tb/tb_upd_serializer.sv
module tb_upd_serializer;
  localparam int N = 100;
  localparam int W = 16;
  localparam int IW = $clog2(N);
  localparam int DW = IW + W;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_full = 1'b0;
  logic [N*W-1:0] mon_vals = '0;
  logic wr_en;
  logic [DW-1:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0]   exp_pend = '0;
  logic [N*W-1:0] exp_prev = '0;

  upd_serializer #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mon_vals(mon_vals),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lowest(logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [W-1:0] val(int i);
    return mon_vals[i*W +: W];
  endfunction

  task automatic set_reg(int i, logic [W-1:0] v);
    mon_vals[i*W +: W] = v;
  endtask

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Inputs are changed just after a falling edge; outputs are sampled 1 time unit later.
  task automatic tick(string req);
    int w;
    logic [DW-1:0] word;
    #1;
    w = lowest(exp_pend);
    if (w >= 0 && !fifo_full) begin
      word = {IW'(w), val(w)};
      check(wr_en === 1'b1, req, "wr_en", 64'(wr_en), 64'd1);
      check(wr_data === word, req, "word", 64'(wr_data), 64'(word));
    end else begin
      check(wr_en === 1'b0, req, "wr_en", 64'(wr_en), 64'd0);
    end
    for (int i = 0; i < N; i++)
      if (val(i) != exp_prev[i*W +: W]) exp_pend[i] = 1'b1;
    if (w >= 0 && !fifo_full) exp_pend[w] = 1'b0;
    exp_prev = mon_vals;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [W-1:0] orig;
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) set_reg(i, W'($urandom));
    end
    @(negedge clk);
    rst_n = 1'b1;
    exp_prev = mon_vals;
    exp_pend = '0;
    repeat (3) tick("R8");

    set_reg(7, val(7) + 1'b1);
    tick("R1");
    tick("R7");
    tick("R1");

    set_reg(99, val(99) ^ 16'h00f0);
    set_reg(3, val(3) ^ 16'h0001);
    set_reg(50, val(50) ^ 16'h8000);
    repeat (4) tick("R2");

    fifo_full = 1'b1;
    set_reg(10, val(10) + 16'd5);
    set_reg(90, val(90) + 16'd9);
    repeat (4) tick("R6");
    fifo_full = 1'b0;
    repeat (3) tick("R6");

    fifo_full = 1'b1;
    set_reg(20, 16'h1111);
    tick("R5");
    set_reg(20, 16'h2222);
    tick("R5");
    fifo_full = 1'b0;
    repeat (2) tick("R5");

    fifo_full = 1'b1;
    orig = val(30);
    set_reg(30, orig ^ 16'h0101);
    tick("R5");
    set_reg(30, orig);
    tick("R5");
    fifo_full = 1'b0;
    repeat (2) tick("R5");

    set_reg(60, val(60) + 16'd3);
    repeat (12) begin
      set_reg(0, val(0) + 1'b1);
      tick("R9");
    end
    repeat (4) tick("R9");

    for (int c = 0; c < 3000; c++) begin
      fifo_full = ($urandom % 5) == 0;
      if (($urandom % 4) == 0) begin
        int k;
        k = int'($urandom % 4) + 1;
        for (int j = 0; j < k; j++) set_reg(int'($urandom % N), W'($urandom));
      end
      tick("R3");
    end
    fifo_full = 1'b0;
    repeat (N + 5) tick("R4");
    summary();
  end
endmodule